// File: doc/BRIEF.md
# Two-Channel Interrupt Enable and Status Combiner

This block gathers two banks of level-sensitive interrupt source lines, a normal bank and a fast bank, and turns each bank into a single request line for a processor. Each bank has its own enable vector. Software never writes that vector directly. It sets bits through one register address and clears bits through another, so two agents can change different enables without a read-modify-write race.

For each bank, software can read two views. The raw view shows the live source lines whatever their enables. The masked view shows only the enabled sources. A bank's request output is high whenever any enabled source is active. The request is combinational from the enable register and the live sources, so it reflects an enable change in the clock cycle right after the write edge.

Accesses that break the access rules complete without effect. A write to a status view, a read of a set or clear address, or any access outside the map returns zero and raises an error flag for one cycle.

Top module: `irq_combiner`

## Requirements
- R1: A read of function code 0 (address bits [1:0] = 0; bit 2 selects the bank, 0 = normal, 1 = fast; higher bits zero) returns the bank's sources ANDed with its enable vector on `rsp_rdata`, registered and valid in the cycle after the access.
- R2: A read of function code 1 (bits [1:0] = 1, bit 2 = bank) returns the bank's live source lines, unaffected by the enable vector, in the cycle after the access.
- R3: A write of function code 2 (bits [1:0] = 2, bit 2 = bank) ORs the write data into that bank's enable vector at the access edge.
- R4: A write of function code 3 (bits [1:0] = 3, bit 2 = bank) clears every enable bit of that bank whose write-data bit is 1 and leaves the other bits unchanged.
- R5: The two banks are independent: set and clear writes addressed with bit 2 = 0 never change the fast bank's enables, and writes with bit 2 = 1 never change the normal bank's enables.
- R6: `irq_req` (normal) and `fiq_req` (fast) are high exactly when the bank's sources ANDed with its enables are nonzero, and they follow an enable write in the cycle right after its edge.
- R7: After reset, both enable vectors are zero, both request outputs are low, `rsp_rdata` is zero and `rsp_err` is low.
- R8: A write to function code 0 or 1, a read of function code 2 or 3, or any access with an address bit above bit 2 set returns zero and drives `rsp_err` high for the single cycle after the access. It changes no enable bit.
- R9: `rsp_rdata` is zero in the cycle after a write and in the cycle after a cycle with no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (4) | Word address: [1:0] function, [2] bank, upper bits must be zero |
| req_wdata | input | DATA_W (32) | Write data, used as a bit mask |
| rsp_rdata | output | DATA_W (32) | Read data, registered |
| rsp_err | output | 1 | One-cycle flag for a rule-breaking access |
| irq_src | input | NSRC (32) | Normal bank source lines |
| fiq_src | input | NSRC (32) | Fast bank source lines |
| irq_req | output | 1 | Normal bank processor request |
| fiq_req | output | 1 | Fast bank processor request |

## Verification
Read data and the error flag pass through one register, so they are due in the cycle after the access edge. Enable changes land at the access edge, and the request outputs follow them combinationally in that same following cycle. The bench drives each access on a falling edge, releases it on the next falling edge, and samples all outputs there, half a period after the edge that produced them. Expected values come from a bench-side copy of both enable vectors that is updated with plain OR and AND-NOT arithmetic as each write is issued.

// File: rtl/irq_combiner_pkg.sv
package irq_combiner_pkg;

   localparam int NUM_BANKS = 2;
   localparam int BANK_NORMAL = 0;
   localparam int BANK_FAST = 1;
   localparam int FN_BITS = 2;
   localparam int DECODE_BITS = FN_BITS + 1;

   typedef enum logic [FN_BITS-1:0] {
      FN_MASKED = 2'd0,
      FN_RAW    = 2'd1,
      FN_SET    = 2'd2,
      FN_CLEAR  = 2'd3
   } reg_fn_e;

endpackage

// File: rtl/irq_access_decode.sv
module irq_access_decode
   import irq_combiner_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic                 valid,
   input  logic                 write,
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_BANKS-1:0] set_stb,
   output logic [NUM_BANKS-1:0] clr_stb,
   output logic                 rd_ok,
   output logic                 rd_raw,
   output logic                 rd_bank,
   output logic                 bad
);

   reg_fn_e fn;
   logic    bank;
   logic    in_map;
   logic    fn_is_status;

   assign fn   = reg_fn_e'(addr[FN_BITS-1:0]);
   assign bank = addr[FN_BITS];

   generate
      if (ADDR_W > DECODE_BITS) begin : g_upper
         assign in_map = (addr[ADDR_W-1:DECODE_BITS] == '0);
      end else begin : g_exact
         assign in_map = 1'b1;
      end
   endgenerate

   assign fn_is_status = (fn == FN_MASKED) || (fn == FN_RAW);

   always_comb begin
      set_stb = '0;
      clr_stb = '0;
      if (valid && write && in_map) begin
         set_stb[bank] = (fn == FN_SET);
         clr_stb[bank] = (fn == FN_CLEAR);
      end
   end

   assign rd_ok   = valid && !write && in_map && fn_is_status;
   assign rd_raw  = (fn == FN_RAW);
   assign rd_bank = bank;
   assign bad     = valid && (!in_map || (write == fn_is_status));

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int NSRC    = 32,
   parameter bit REQ_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_stb,
   input  logic            clr_stb,
   input  logic [NSRC-1:0] wmask,
   input  logic [NSRC-1:0] src,
   output logic [NSRC-1:0] masked,
   output logic            req
);

   logic [NSRC-1:0] enable_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable_q <= '0;
      end else if (set_stb) begin
         enable_q <= enable_q | wmask;
      end else if (clr_stb) begin
         enable_q <= enable_q & ~wmask;
      end
   end

   assign masked = src & enable_q;

   generate
      if (REQ_REG) begin : g_req_flop
         logic req_q;
         always_ff @(posedge clk) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= |masked;
         end
         assign req = req_q;
      end else begin : g_req_comb
         assign req = |masked;
      end
   endgenerate

   p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((enable_q & $past(wmask)) == $past(wmask)))
      else $error("set write did not raise all enable bits");

   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && !set_stb) |=> ((enable_q & $past(wmask)) == '0))
      else $error("clear write left enable bits set");

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_stb && !clr_stb) |=> $stable(enable_q))
      else $error("enable vector changed without a set or clear");

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
   import irq_combiner_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 32,
   parameter int NSRC    = 32,
   parameter bit REQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   input  logic [NSRC-1:0]   irq_src,
   input  logic [NSRC-1:0]   fiq_src,
   output logic              irq_req,
   output logic              fiq_req
);

   generate
      if (NSRC < 1 || NSRC > DATA_W) begin : g_bad_nsrc
         $error("NSRC must lie between 1 and DATA_W");
      end
      if (ADDR_W < DECODE_BITS) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic [NUM_BANKS-1:0] set_stb;
   logic [NUM_BANKS-1:0] clr_stb;
   logic                 rd_ok;
   logic                 rd_raw;
   logic                 rd_bank;
   logic                 bad;
   logic [NSRC-1:0]      wmask;
   logic [NSRC-1:0]      src_v    [NUM_BANKS];
   logic [NSRC-1:0]      masked_v [NUM_BANKS];
   logic [NUM_BANKS-1:0] req_v;
   logic [NSRC-1:0]      rd_sel;

   irq_access_decode #(.ADDR_W(ADDR_W)) u_decode (
      .valid   (req_valid),
      .write   (req_write),
      .addr    (req_addr),
      .set_stb (set_stb),
      .clr_stb (clr_stb),
      .rd_ok   (rd_ok),
      .rd_raw  (rd_raw),
      .rd_bank (rd_bank),
      .bad     (bad)
   );

   assign wmask = req_wdata[NSRC-1:0];
   assign src_v[BANK_NORMAL] = irq_src;
   assign src_v[BANK_FAST]   = fiq_src;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         irq_mask_bank #(.NSRC(NSRC), .REQ_REG(REQ_REG)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (set_stb[b]),
            .clr_stb (clr_stb[b]),
            .wmask   (wmask),
            .src     (src_v[b]),
            .masked  (masked_v[b]),
            .req     (req_v[b])
         );
      end
   endgenerate

   assign irq_req = req_v[BANK_NORMAL];
   assign fiq_req = req_v[BANK_FAST];

   assign rd_sel = rd_raw ? src_v[rd_bank] : masked_v[rd_bank];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_rdata <= rd_ok ? DATA_W'(rd_sel) : '0;
         rsp_err   <= bad;
      end
   end

   p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_err)
      else $error("error flag without an access");

   p_write_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_rdata == '0))
      else $error("read data nonzero after a write");

   p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!REQ_REG && irq_req) |-> (irq_src != '0))
      else $error("normal request with no active source");

   p_fiq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!REQ_REG && fiq_req) |-> (fiq_src != '0))
      else $error("fast request with no active source");

endmodule

// File: tb/irq_combiner_test.sv
module irq_combiner_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [3:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic        rsp_err;
   logic [31:0] irq_src = '0;
   logic [31:0] fiq_src = '0;
   logic        irq_req;
   logic        fiq_req;

   int          n_checks = 0;
   int          n_errors = 0;
   logic [31:0] en_m [2];

   always #5 clk = ~clk;

   irq_combiner uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
      .rsp_err(rsp_err), .irq_src(irq_src), .fiq_src(fiq_src),
      .irq_req(irq_req), .fiq_req(fiq_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one access: driven on a falling edge, released on the next, outputs valid then
   task automatic access(input logic wr, input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
   endtask

   function automatic logic [31:0] src_of(input int b);
      return (b == 0) ? irq_src : fiq_src;
   endfunction

   task automatic check_reqs(input string req);
      check(req, {31'b0, irq_req}, {31'b0, |(irq_src & en_m[0])});
      check(req, {31'b0, fiq_req}, {31'b0, |(fiq_src & en_m[1])});
   endtask

   task automatic check_views(input int b);
      access(1'b0, 4'(b*4 + 0), '0);
      check("R1 masked read", rsp_rdata, src_of(b) & en_m[b]);
      check("R1 no error", {31'b0, rsp_err}, 32'h0);
      access(1'b0, 4'(b*4 + 1), '0);
      check("R2 raw read", rsp_rdata, src_of(b));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin : stim
      en_m[0] = '0; en_m[1] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7 reset state
      check("R7 rdata", rsp_rdata, 32'h0);
      check("R7 err", {31'b0, rsp_err}, 32'h0);
      irq_src = 32'hFFFF_FFFF; fiq_src = 32'hFFFF_FFFF;
      #1;
      check("R7 irq_req", {31'b0, irq_req}, 32'h0);
      check("R7 fiq_req", {31'b0, fiq_req}, 32'h0);
      for (int b = 0; b < 2; b++) check_views(b);

      // walking set per bank, R3 R5 R6
      for (int b = 0; b < 2; b++) begin
         for (int i = 0; i < 32; i++) begin
            irq_src = 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101);
            fiq_src = ~irq_src ^ 32'(i);
            access(1'b1, 4'(b*4 + 2), 32'h1 << i);
            en_m[b] = en_m[b] | (32'h1 << i);
            check_reqs("R6 request after set");
            check_views(b);
            check_views(1 - b);   // R5 other bank untouched
         end
      end

      // clear sweep, R4 R6
      for (int b = 0; b < 2; b++) begin
         for (int i = 0; i < 32; i += 3) begin
            irq_src = 32'hA5A5_0F0F << (i % 8);
            fiq_src = 32'h0FF0_33CC >> (i % 5);
            access(1'b1, 4'(b*4 + 3), 32'h7 << i);
            en_m[b] = en_m[b] & ~(32'h7 << i);
            check_reqs("R4 R6 request after clear");
            check_views(b);
            check_views(1 - b);
         end
      end

      // single enabled source toggling, R6
      access(1'b1, 4'(0*4 + 3), 32'hFFFF_FFFF); en_m[0] = '0;
      access(1'b1, 4'(1*4 + 3), 32'hFFFF_FFFF); en_m[1] = '0;
      access(1'b1, 4'(0*4 + 2), 32'h0000_0100); en_m[0] = 32'h0000_0100;
      irq_src = 32'hFFFF_FEFF; fiq_src = '0; #1;
      check_reqs("R6 only disabled sources active");
      irq_src = 32'h0000_0100; #1;
      check_reqs("R6 enabled source active");
      access(1'b1, 4'(1*4 + 2), 32'h8000_0000); en_m[1] = 32'h8000_0000;
      fiq_src = 32'h8000_0000; #1;
      check_reqs("R6 fast request");

      // R8 rule-breaking accesses
      irq_src = 32'hDEAD_BEEF; fiq_src = 32'hCAFE_F00D;
      for (int b = 0; b < 2; b++) begin
         for (int f = 0; f < 4; f++) begin
            logic wr;
            wr = (f < 2);   // write to status, or read of set/clear
            access(wr, 4'(b*4 + f), 32'hFFFF_FFFF);
            check("R8 bad access data", rsp_rdata, 32'h0);
            check("R8 bad access err", {31'b0, rsp_err}, 32'h1);
            @(negedge clk);
            check("R8 err single cycle", {31'b0, rsp_err}, 32'h0);
            check_views(0);
            check_views(1);
         end
      end
      for (int a = 8; a < 16; a++) begin
         access(1'b1, 4'(a), 32'hFFFF_FFFF);
         check("R8 unmapped write err", {31'b0, rsp_err}, 32'h1);
         access(1'b0, 4'(a), '0);
         check("R8 unmapped read data", rsp_rdata, 32'h0);
         check("R8 unmapped read err", {31'b0, rsp_err}, 32'h1);
      end
      check_views(0);
      check_views(1);
      check_reqs("R8 requests unchanged");

      // R9 write and idle cycles give zero data
      access(1'b1, 4'(0*4 + 2), 32'h0000_0001); en_m[0] |= 32'h1;
      check("R9 data after write", rsp_rdata, 32'h0);
      check("R9 no err after legal write", {31'b0, rsp_err}, 32'h0);
      @(negedge clk);
      check("R9 data when idle", rsp_rdata, 32'h0);
      check_views(0);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule